// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the device-side control of a word-wide parallel NOR flash. It watches three active-low strobes from an asynchronous host bus: chip enable, write enable and output enable. It brings them into its own clock domain and turns each bus write into an address/data pair. It then follows the multi-cycle unlock protocol that guards program and erase operations. A recognised sequence launches one of four internal operations: word program, sector erase, block erase or whole-chip erase. A busy timer then runs for that operation.

While the timer runs, the decoder ignores every write. Reads return a status word instead of array contents, so the host can poll for completion. The bit-7 polling bit and the bit-6 toggle bit serve that purpose. When the timer expires, the operation is applied to the array and reads return real data again.

The array is a small behavioural model. Each 2K-word sector keeps only its first few words in flops, so the address space and the sector and block geometry stay at full size while storage stays small.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: A bus write cycle exists only while the synchronised chip enable and write enable are both low. The address is taken when that state begins, which is the later falling edge. The data is taken when it ends, which is the earlier rising edge. A write-enable pulse while chip enable is high has no effect.
- R2: `dq_oe_o` is 1 only while the synchronised chip enable and output enable are both low. While it is 0, `dq_o` is all zeros.
- R3: Word program is four write cycles: AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h, then the target address and word. Only data bits [7:0] are compared in command cycles. The stored word becomes the old word AND the new word, so bits can only clear.
- R4: Erase begins with five cycles: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh. A sixth cycle of 30h erases the 2K-word sector selected by address bits [15:11] to all ones. Other sectors are untouched.
- R5: The same prefix with a sixth cycle of 50h erases the 32K-word block selected by address bit [15] to all ones.
- R6: A sixth cycle of 10h erases the whole array, but only when its address is 5555h. At any other address, nothing happens.
- R7: A wrong address or data at any step returns the decoder to idle and changes nothing. A later correct sequence still works.
- R8: While an operation is in progress, every write is ignored, including complete program sequences.
- R9: While busy, a read returns a status word. Bit 7 is the complement of the programmed bit 7 for a program, and 0 for an erase. Bit 6 inverts after each completed read. All other bits are 0.
- R10: Busy lasts `PROG_CYC` clock cycles for a program and `ERASE_CYC` cycles for an erase. After that, reads return array data.
- R11: Only words at sector offsets below 2^`KEEP_AW` are stored. Other addresses read FFFFh, and programs to them have no effect.
- R12: After reset, the decoder is idle and not busy, and every word reads FFFFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable strobe, active low, asynchronous |
| we_ni | input | 1 | Write enable strobe, active low, asynchronous |
| oe_ni | input | 1 | Output enable strobe, active low, asynchronous |
| addr_i | input | ADDR_W | Word address bus |
| data_i | input | DATA_W | Write data bus |
| dq_o | output | DATA_W | Read data or status word |
| dq_oe_o | output | 1 | Read data valid (bus drive enable) |

## Verification
Random programs of random data to random stored words are checked against a bench model of AND-only writes. This separates correct bit clearing from overwriting. Sector, block and chip erases are mixed in to show which words each one reaches.

Sequences with one step corrupted, a write-enable pulse without chip enable, and a chip erase at the wrong address must all leave the array unchanged. A write cycle whose address and data change midway tells apart capture at the start from capture at the end.

Polling reads during program and erase check the complemented bit 7, the alternating bit 6 and the ignored writes. Reads after the busy window confirm the result is applied.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_U1    = 3'd1,
    S_U2    = 3'd2,
    S_PROG  = 3'd3,
    S_E3    = 3'd4,
    S_E4    = 3'd5,
    S_E5    = 3'd6
  } seq_e;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_DAT_A  = 8'hAA;
  localparam logic [7:0]  KEY_DAT_B  = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam logic [7:0]  CMD_BLK    = 8'h50;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  output logic wr_start_o,
  output logic wr_end_o,
  output logic rd_act_o,
  output logic rd_end_o
);

  localparam int NSTB = 3;

  logic [NSTB-1:0] raw_n;
  logic [NSTB-1:0] low;
  logic            wr_act, rd_act;
  logic            wr_q, rd_q;

  assign raw_n = {oe_ni, we_ni, ce_ni};

  for (genvar g = 0; g < NSTB; g++) begin : g_sync
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '1;
      else         sh_q <= {sh_q[STAGES-2:0], raw_n[g]};
    end
    assign low[g] = ~sh_q[STAGES-1];
  end

  assign wr_act = low[0] & low[1];
  assign rd_act = low[0] & low[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end
  end

  assign wr_start_o = wr_act & ~wr_q;
  assign wr_end_o   = ~wr_act & wr_q;
  assign rd_act_o   = rd_act;
  assign rd_end_o   = ~rd_act & rd_q;

  // R1: a write cycle cannot open twice without closing in between
  a_r1_start_needs_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |=> !wr_start_o);
  a_r1_open_close_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_start_o, wr_end_o}));

endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_start_i,
  input  logic              wr_end_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              busy_i,
  output logic              launch_o,
  output op_e               op_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0] tgt_data_o
);

  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(KEY_ADDR_B);

  seq_e              state_q, state_d;
  logic [ADDR_W-1:0] cyc_addr_q;
  logic              hit_a, hit_b;
  logic [7:0]        code;
  logic              go_d;
  op_e               op_d;

  assign code  = data_i[7:0];
  assign hit_a = (cyc_addr_q == ADR_A);
  assign hit_b = (cyc_addr_q == ADR_B);

  // address captured when the write cycle opens
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cyc_addr_q <= '0;
    else if (wr_start_i) cyc_addr_q <= addr_i;
  end

  always_comb begin
    state_d = state_q;
    go_d    = 1'b0;
    op_d    = OP_PROG;
    if (busy_i) begin
      state_d = S_IDLE;
    end else if (wr_end_i) begin
      state_d = S_IDLE;
      unique case (state_q)
        S_IDLE: if (hit_a && code == KEY_DAT_A) state_d = S_U1;
        S_U1:   if (hit_b && code == KEY_DAT_B) state_d = S_U2;
        S_U2: begin
          if (hit_a && code == CMD_PROG)       state_d = S_PROG;
          else if (hit_a && code == CMD_ERASE) state_d = S_E3;
        end
        S_PROG: begin
          go_d = 1'b1;
          op_d = OP_PROG;
        end
        S_E3: if (hit_a && code == KEY_DAT_A) state_d = S_E4;
        S_E4: if (hit_b && code == KEY_DAT_B) state_d = S_E5;
        S_E5: begin
          if (code == CMD_SECT) begin
            go_d = 1'b1;
            op_d = OP_SECT;
          end else if (code == CMD_BLK) begin
            go_d = 1'b1;
            op_d = OP_BLK;
          end else if (code == CMD_CHIP && hit_a) begin
            go_d = 1'b1;
            op_d = OP_CHIP;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      launch_o   <= 1'b0;
      op_o       <= OP_PROG;
      tgt_addr_o <= '0;
      tgt_data_o <= '0;
    end else begin
      state_q  <= state_d;
      launch_o <= go_d;
      if (go_d) begin
        op_o       <= op_d;
        tgt_addr_o <= cyc_addr_q;
        tgt_data_o <= data_i;
      end
    end
  end

  // R8: once busy the sequence tracker is parked in idle
  a_r8_busy_parks_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> state_q == S_IDLE);
  // R7: a launch only follows the final step of a sequence
  a_r7_launch_from_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> ($past(state_q) == S_PROG || $past(state_q) == S_E5));
  // R6: chip erase only launches when its final cycle hit the key address
  a_r6_chip_key_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o && op_o == OP_CHIP) |-> tgt_addr_o == ADR_A);

endmodule

// File: rtl/busy_timer.sv
module busy_timer
  import nor_cmd_pkg::*;
#(
  parameter int PROG_CYC  = 24,
  parameter int ERASE_CYC = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_i,
  output logic busy_o,
  output logic done_o
);

  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LD_PROG  = CW'(PROG_CYC);
  localparam logic [CW-1:0] LD_ERASE = CW'(ERASE_CYC);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= (op_i == OP_PROG) ? LD_PROG : LD_ERASE;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CW'(1));

  // R10: the load value matches the operation class
  a_r10_load_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q && cnt_q == (($past(op_i) == OP_PROG) ? LD_PROG : LD_ERASE));
  a_r10_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q > CW'(1) && !start_i) |=> busy_q && cnt_q == $past(cnt_q) - 1'b1);
  // R8: no second launch arrives while an operation runs
  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);

endmodule

// File: rtl/flash_array.sv
module flash_array
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int SECT_AW = 11,
  parameter int BLK_AW  = 15,
  parameter int KEEP_AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_word_o
);

  localparam int SEC_W  = ADDR_W - SECT_AW;
  localparam int BLK_W  = ADDR_W - BLK_AW;
  localparam int IDX_W  = SEC_W + KEEP_AW;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int GAP_W  = SECT_AW - KEEP_AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  function automatic logic stored(input logic [ADDR_W-1:0] a);
    return a[SECT_AW-1:KEEP_AW] == GAP_W'(0);
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:SECT_AW], a[KEEP_AW-1:0]};
  endfunction

  function automatic logic [SEC_W-1:0] sect_of(input int e);
    logic [IDX_W-1:0] ev;
    ev = IDX_W'(e);
    return ev[IDX_W-1:KEEP_AW];
  endfunction

  function automatic logic [BLK_W-1:0] blk_of(input int e);
    logic [IDX_W-1:0] ev;
    ev = IDX_W'(e);
    return ev[IDX_W-1:IDX_W-BLK_W];
  endfunction

  logic [IDX_W-1:0] w_idx;
  assign w_idx = idx_of(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '1;
    end else if (commit_i) begin
      unique case (op_i)
        OP_PROG: if (stored(addr_i)) mem_q[w_idx] <= mem_q[w_idx] & data_i;
        OP_SECT: for (int e = 0; e < DEPTH; e++)
                   if (sect_of(e) == addr_i[ADDR_W-1:SECT_AW]) mem_q[e] <= '1;
        OP_BLK:  for (int e = 0; e < DEPTH; e++)
                   if (blk_of(e) == addr_i[ADDR_W-1:BLK_AW]) mem_q[e] <= '1;
        OP_CHIP: for (int e = 0; e < DEPTH; e++) mem_q[e] <= '1;
        default: ;
      endcase
    end
  end

  assign rd_word_o = stored(rd_addr_i) ? mem_q[idx_of(rd_addr_i)] : '1;

  // checker state for the assertions below
  logic              all_ones;
  logic              chk_vld_q;
  logic [IDX_W-1:0]  chk_idx_q;
  logic [DATA_W-1:0] chk_old_q;

  always_comb begin
    all_ones = 1'b1;
    for (int e = 0; e < DEPTH; e++) all_ones = all_ones & (&mem_q[e]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_vld_q <= 1'b0;
      chk_idx_q <= '0;
      chk_old_q <= '0;
    end else begin
      chk_vld_q <= commit_i && op_i == OP_PROG && stored(addr_i);
      chk_idx_q <= w_idx;
      chk_old_q <= mem_q[w_idx];
    end
  end

  // R3: a program never sets a bit that was clear
  a_r3_prog_clears_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_vld_q |-> (mem_q[chk_idx_q] & ~chk_old_q) == '0);
  // R6: chip erase leaves every stored word at all ones
  a_r6_chip_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && op_i == OP_CHIP) |=> all_ones);
  // R11: unstored addresses always read as erased
  a_r11_gap_reads_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stored(rd_addr_i) |-> &rd_word_o);

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int SECT_AW   = 11,
  parameter int BLK_AW    = 15,
  parameter int KEEP_AW   = 2,
  parameter int SYNC_STG  = 2,
  parameter int PROG_CYC  = 24,
  parameter int ERASE_CYC = 96
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);

  logic              wr_start, wr_end, rd_act, rd_end;
  logic              launch, busy, done;
  op_e               op;
  logic [ADDR_W-1:0] tgt_addr;
  logic [DATA_W-1:0] tgt_data;
  logic [DATA_W-1:0] arr_word, stat_word;
  logic              tgl_q;

  strobe_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_ni      (ce_ni),
    .we_ni      (we_ni),
    .oe_ni      (oe_ni),
    .wr_start_o (wr_start),
    .wr_end_o   (wr_end),
    .rd_act_o   (rd_act),
    .rd_end_o   (rd_end)
  );

  cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_start_i (wr_start),
    .wr_end_i   (wr_end),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .busy_i     (busy),
    .launch_o   (launch),
    .op_o       (op),
    .tgt_addr_o (tgt_addr),
    .tgt_data_o (tgt_data)
  );

  busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (launch),
    .op_i    (op),
    .busy_o  (busy),
    .done_o  (done)
  );

  flash_array #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .SECT_AW (SECT_AW),
    .BLK_AW (BLK_AW), .KEEP_AW (KEEP_AW)
  ) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (done),
    .op_i      (op),
    .addr_i    (tgt_addr),
    .data_i    (tgt_data),
    .rd_addr_i (addr_i),
    .rd_word_o (arr_word)
  );

  // toggle bit flips after each read finished while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tgl_q <= 1'b0;
    else if (launch)          tgl_q <= 1'b0;
    else if (busy && rd_end)  tgl_q <= ~tgl_q;
  end

  always_comb begin
    stat_word    = '0;
    stat_word[7] = (op == OP_PROG) ? ~tgt_data[7] : 1'b0;
    stat_word[6] = tgl_q;
  end

  assign dq_oe_o = rd_act;
  assign dq_o    = !rd_act ? '0 : (busy ? stat_word : arr_word);

  // R10: a launch always opens a busy window
  a_r10_launch_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> busy);
  // R9: toggle bit only moves while busy
  a_r9_tgl_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(busy) && !$past(launch)) |-> $stable(tgl_q));
  // R2: nothing is driven outside a read
  a_r2_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> dq_o == '0);

endmodule

// File: tb/nor_cmd_ctrl_test.sv
module nor_cmd_ctrl_test;

  localparam int PCYC = 48;
  localparam int ECYC = 160;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [15:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dq;
  logic        dq_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit fin = 0;

  logic [15:0] exp_mem [128];

  always #2 clk = ~clk;

  nor_cmd_ctrl #(.PROG_CYC(PCYC), .ERASE_CYC(ECYC)) uut (
    .clk_i (clk), .rst_ni (rst_ni), .ce_ni (ce_n), .we_ni (we_n), .oe_ni (oe_n),
    .addr_i (addr), .data_i (din), .dq_o (dq), .dq_oe_o (dq_oe)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      errors++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic bit is_stored(input logic [15:0] a);
    return a[10:2] == 9'd0;
  endfunction

  function automatic int midx(input logic [15:0] a);
    return {a[15:11], a[1:0]};
  endfunction

  function automatic logic [15:0] exp_word(input logic [15:0] a);
    return is_stored(a) ? exp_mem[midx(a)] : 16'hFFFF;
  endfunction

  function automatic logic [15:0] rnd_addr();
    logic [15:0] a;
    a = '0;
    a[15:11] = 5'($urandom_range(31));
    a[1:0]   = 2'($urandom_range(3));
    return a;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // address and data change in the middle of the cycle
  task automatic wr_mix(input logic [15:0] a0, input logic [15:0] d0,
                        input logic [15:0] a1, input logic [15:0] d1);
    @(negedge clk);
    addr = a0; din = d0; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (4) @(negedge clk);
    addr = a1; din = d1;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_noce(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; din = d;
    we_n = 1'b0;
    repeat (5) @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v, output logic oe);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (5) @(negedge clk);
    v = dq; oe = dq_oe;
    oe_n = 1'b1; ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a);
    logic [15:0] v;
    logic        o;
    rd(a, v, o);
    check(req, v, exp_word(a));
  endtask

  task automatic prog(input logic [15:0] a, input logic [15:0] d);
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h00A0);
    wr(a, d);
  endtask

  task automatic erase(input logic [7:0] cmd, input logic [15:0] a);
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h0080);
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(a, {8'h00, cmd});
  endtask

  task automatic m_prog(input logic [15:0] a, input logic [15:0] d);
    if (is_stored(a)) exp_mem[midx(a)] = exp_mem[midx(a)] & d;
  endtask

  task automatic m_sect(input logic [15:0] a);
    for (int i = 0; i < 128; i++) if (i[6:2] == a[15:11]) exp_mem[i] = 16'hFFFF;
  endtask

  task automatic m_blk(input logic [15:0] a);
    for (int i = 0; i < 128; i++) if (i[6] == a[15]) exp_mem[i] = 16'hFFFF;
  endtask

  task automatic wait_prog();
    repeat (PCYC + 10) @(negedge clk);
  endtask

  task automatic wait_erase();
    repeat (ECYC + 10) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v, a, b, d;
    logic [15:0] st [4];
    logic        o;

    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 128; i++) exp_mem[i] = 16'hFFFF;

    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    check("R12 dq_oe idle", {15'd0, dq_oe}, 16'd0);
    check("R12 dq idle", dq, 16'h0000);
    rd(16'h0801, v, o);
    check("R12 erased word", v, 16'hFFFF);
    check("R2 read drives", {15'd0, o}, 16'd1);

    // R2 ce low with oe high: no drive
    @(negedge clk); ce_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 oe high no drive", {15'd0, dq_oe}, 16'd0);
    ce_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 program with polling, R9 status, R10 duration
    a = 16'h1802; d = 16'h3C5A;
    prog(a, d);
    for (int k = 0; k < 4; k++) begin
      rd(a, v, o);
      st[k] = v;
    end
    check("R9 poll bit7 prog", {15'd0, st[0][7]}, {15'd0, ~d[7]});
    check("R9 status other bits", st[0] & 16'hFF3F, 16'h0000);
    for (int k = 1; k < 4; k++)
      check("R9 toggle bit", {15'd0, st[k][6]}, {15'd0, ~st[k-1][6]});
    check("R10 still busy late", {15'd0, st[3][7]}, {15'd0, ~d[7]});
    wait_prog();
    m_prog(a, d);
    rd_chk("R10 R3 data after program", a);

    // R3 AND behaviour and low-byte compare
    prog(a, 16'hF00F);
    wait_prog();
    m_prog(a, 16'hF00F);
    rd_chk("R3 and only", a);
    wr(16'h5555, 16'h12AA);
    wr(16'h2AAA, 16'hFF55);
    wr(16'h5555, 16'h77A0);
    wr(16'h0001, 16'h8181);
    wait_prog();
    m_prog(16'h0001, 16'h8181);
    rd_chk("R3 high byte ignored in cmd", 16'h0001);

    // R1 address at start, data at end
    a = 16'h1801; b = 16'h2002;
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h00A0);
    wr_mix(a, 16'h0000, b, 16'h5A3C);
    wait_prog();
    m_prog(a, 16'h5A3C);
    rd_chk("R1 addr at open", a);
    rd_chk("R1 late addr untouched", b);

    // R1 we pulse without ce
    wr_noce(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h00A0);
    wr(16'h2803, 16'h0000);
    wait_prog();
    rd_chk("R1 no ce no write", 16'h2803);

    // R11 unstored word
    prog(16'h0008, 16'h0000);
    wait_prog();
    rd_chk("R11 gap reads ones", 16'h0008);

    // R4 sector erase, R8 writes ignored, R9 erase status
    prog(16'h3000, 16'h1111); wait_prog(); m_prog(16'h3000, 16'h1111);
    prog(16'h3803, 16'h2222); wait_prog(); m_prog(16'h3803, 16'h2222);
    erase(8'h30, 16'h3000 | 16'h0123);
    prog(16'h0002, 16'h0000);
    rd(16'h3000, v, o);
    check("R9 erase poll bit7", {15'd0, v[7]}, 16'd0);
    wait_erase();
    m_sect(16'h3000);
    rd_chk("R4 sector erased", 16'h3000);
    rd_chk("R4 neighbour kept", 16'h3803);
    rd_chk("R8 prog during erase ignored", 16'h0002);

    // R5 block erase
    prog(16'h8001, 16'h0F0F); wait_prog(); m_prog(16'h8001, 16'h0F0F);
    prog(16'hF802, 16'h0F0F); wait_prog(); m_prog(16'hF802, 16'h0F0F);
    erase(8'h50, 16'h8000);
    wait_erase();
    m_blk(16'h8000);
    rd_chk("R5 block word a", 16'h8001);
    rd_chk("R5 block word b", 16'hF802);
    rd_chk("R5 other block kept", 16'h1802);

    // R6 chip erase at wrong address, then correct
    erase(8'h10, 16'h5554);
    wait_erase();
    rd_chk("R6 wrong addr no erase", 16'h1802);
    erase(8'h10, 16'h5555);
    wait_erase();
    for (int i = 0; i < 128; i++) exp_mem[i] = 16'hFFFF;
    rd_chk("R6 chip erased", 16'h1802);
    rd_chk("R6 chip erased b", 16'h0001);

    // R7 corrupted steps
    for (int s = 0; s < 3; s++) begin
      a = rnd_addr();
      wr(16'h5555, (s == 0) ? 16'h00AB : 16'h00AA);
      wr(16'h2AAA, (s == 1) ? 16'h0056 : 16'h0055);
      wr((s == 2) ? 16'h5556 : 16'h5555, 16'h00A0);
      wr(a, 16'h0000);
      wait_prog();
      rd_chk("R7 bad step no change", a);
    end

    // random mix
    for (int it = 0; it < 40; it++) begin
      int sel;
      sel = $urandom_range(9);
      a = rnd_addr();
      d = 16'($urandom);
      if (sel < 6) begin
        prog(a, d); wait_prog(); m_prog(a, d);
        rd_chk("R3 random program", a);
      end else if (sel < 8) begin
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, (sel == 6) ? 16'h0054 : 16'h0055);
        wr(16'h5555, (sel == 7) ? 16'h00A4 : 16'h00A0);
        wr(a, d);
        wait_prog();
        rd_chk("R7 random bad sequence", a);
      end else begin
        erase(8'h30, a); wait_erase(); m_sect(a);
        rd_chk("R4 random sector erase", a);
      end
      rd_chk("R11 random other word", rnd_addr());
    end

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule